// File: doc/BRIEF.md
# Per-Bit Fan-Out Interrupt Aggregator

The block collects 32 level-sensitive source lines and reports them to software through a 32-bit enable word and a 32-bit status word. Each of the low ten status bits has its own output interrupt line. A rising edge on the OR of all sources is an event. On an event, the sources that are high and enabled form a select word. Each selected bit below ten either raises its status bit and its output, or is held as pending when that bit is busy or masked.

Software acknowledges interrupts by writing ones to the status word. Each acknowledged bit is resolved on its own: a held pending interrupt is replayed at once on that bit, and otherwise that bit's output drops. The enable word is sticky. Once no new bits are being added, the same write port masks and unmasks bits while a handler runs. Both words share one register port with a single address bit: address 0 selects enable, address 1 selects status. Reads are combinational.

Top module: `intc_fanout_agg`

## Requirements
- R1: After reset, irq_o and zero_wr_o are low, and both the enable readback (address 0) and the status readback (address 1) are zero.
- R2: An event occurs in a cycle where the OR of src_i is high and was low in the previous cycle. Its select word is src_i AND the enable word. For each selected bit i below 10 whose mask and status bits are clear, status bit i and irq_o[i] are high from the next cycle. Sources that stay high cause no further event, and bits whose enable is clear are ignored.
- R3: Status bits 10 to 31 always read as zero, and selecting sources 10 to 31 changes no output.
- R4: A selected bit below 10 whose status bit or mask bit is already set becomes pending. Its status bit and irq_o bit do not change.
- R5: A nonzero, not-all-ones write to address 1 clears the written status bits. For each written bit i below 10, two cases apply. If bit i is pending, status bit i and irq_o[i] are set and the pending bit is cleared. Otherwise irq_o[i] goes low. Unwritten bits are not affected.
- R6: A write of zero to address 1 changes no state, and zero_wr_o is high for exactly the following cycle.
- R7: A write of all ones to address 1 clears every status bit. It leaves irq_o and the pending bits unchanged.
- R8: A write to address 0 ORs its data into the enable word. Address 0 then reads back the data last written.
- R9: A nonzero write to address 0 that adds no enable bits computes change = readback XOR data. If change AND data is nonzero, the mask bits in change are cleared; otherwise they are set. A zero write to a nonzero enable word takes the second path.
- R10: When a register write and an event fall in the same cycle, the write is applied first and the event is resolved against the state the write leaves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Source interrupt levels |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 enable, 1 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Readback of the selected register |
| irq_o | output | 10 | Per-bit output interrupt lines |
| zero_wr_o | output | 1 | One-cycle flag for a zero status write |

## Verification
Pending and mask bits cannot be read, so a corrupted pending or mask bit shows up only at the next acknowledge of that bit or the next event on it. It appears as a missing or spurious replay on one irq_o line, one cycle after the write. A wrong status bit shows at once on the status readback. A wrong enable or edge state shows one cycle after the next source edge, as a line that rises when it should not, or fails to rise. A reference model in the bench replays every stimulus, so each of these errors surfaces within one step of the cycle where it first becomes visible.

// File: rtl/agg_pkg.sv
package agg_pkg;
  typedef enum logic {
    REG_EN   = 1'b0,
    REG_STAT = 1'b1
  } agg_reg_e;
endpackage

// File: rtl/agg_any_rise.sv
module agg_any_rise #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  output logic         ev_o
);
  logic any_q;
  logic any_d;

  assign any_d = |src_i;
  assign ev_o  = any_d & ~any_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) any_q <= 1'b0;
    else         any_q <= any_d;
endmodule

// File: rtl/agg_en_ctrl.sv
module agg_en_ctrl #(
  parameter int W = 32,
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] en_nx_o,
  output logic [N-1:0] mask_nx_o,
  output logic [W-1:0] shadow_o
);
  logic [W-1:0] en_q, en_d, sh_q, sh_d, ch;
  logic [N-1:0] mk_q, mk_d;

  always_comb begin
    en_d = en_q;
    sh_d = sh_q;
    mk_d = mk_q;
    ch   = sh_q ^ data_i;
    if (wr_i) begin
      sh_d = data_i;
      if (data_i == '0 && en_q == '0) begin
        sh_d = '0;
      end else if ((en_q | data_i) != en_q) begin
        en_d = en_q | data_i;   // growing enable leaves mask alone
      end else if (|(ch & data_i)) begin
        mk_d = mk_q & ~ch[N-1:0];
      end else begin
        mk_d = mk_q | ch[N-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      en_q <= '0;
      sh_q <= '0;
      mk_q <= '0;
    end else begin
      en_q <= en_d;
      sh_q <= sh_d;
      mk_q <= mk_d;
    end

  assign en_nx_o   = en_d;
  assign mask_nx_o = mk_d;
  assign shadow_o  = sh_q;
endmodule

// File: rtl/agg_bit_slice.sv
module agg_bit_slice (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,     // nonzero status write touching this bit
  input  logic replay_i,  // write is not the all-ones initialise
  input  logic hit_i,     // event selects this bit
  input  logic mask_i,
  output logic stat_o,
  output logic irq_o
);
  logic stat_q, pend_q, irq_q;
  logic stat_d, pend_d, irq_d;

  always_comb begin
    stat_d = stat_q;
    pend_d = pend_q;
    irq_d  = irq_q;
    if (ack_i) begin
      stat_d = 1'b0;
      if (replay_i) begin
        if (pend_d) begin
          stat_d = 1'b1;
          pend_d = 1'b0;
          irq_d  = 1'b1;
        end else begin
          irq_d = 1'b0;
        end
      end
    end
    if (hit_i) begin
      if (mask_i || stat_d) pend_d = 1'b1;
      else begin
        stat_d = 1'b1;
        irq_d  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      stat_q <= 1'b0;
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      pend_q <= pend_d;
      irq_q  <= irq_d;
    end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/intc_fanout_agg.sv
module intc_fanout_agg #(
  parameter int SRC_W = 32,
  parameter int OUT_N = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] src_i,
  input  logic             wr_i,
  input  logic             addr_i,
  input  logic [SRC_W-1:0] wdata_i,
  output logic [SRC_W-1:0] rdata_o,
  output logic [OUT_N-1:0] irq_o,
  output logic             zero_wr_o
);
  import agg_pkg::*;

  localparam int HI_W = SRC_W - OUT_N;

  logic             ev;
  logic             en_wr, st_wr, replay;
  logic [SRC_W-1:0] en_nx, shadow;
  logic [OUT_N-1:0] mask_nx, stat;
  logic             zero_q;

  assign en_wr  = wr_i && (addr_i == REG_EN);
  assign st_wr  = wr_i && (addr_i == REG_STAT) && (wdata_i != '0);
  assign replay = ~&wdata_i;

  agg_any_rise #(.W(SRC_W)) u_rise (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .src_i (src_i),
    .ev_o  (ev)
  );

  agg_en_ctrl #(.W(SRC_W), .N(OUT_N)) u_en (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_i     (en_wr),
    .data_i   (wdata_i),
    .en_nx_o  (en_nx),
    .mask_nx_o(mask_nx),
    .shadow_o (shadow)
  );

  for (genvar i = 0; i < OUT_N; i++) begin : g_bit
    agg_bit_slice u_slice (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ack_i   (st_wr && wdata_i[i]),
      .replay_i(replay),
      .hit_i   (ev && src_i[i] && en_nx[i]),
      .mask_i  (mask_nx[i]),
      .stat_o  (stat[i]),
      .irq_o   (irq_o[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) zero_q <= 1'b0;
    else         zero_q <= wr_i && (addr_i == REG_STAT) && (wdata_i == '0);

  assign zero_wr_o = zero_q;
  assign rdata_o   = (addr_i == REG_EN) ? shadow : {{HI_W{1'b0}}, stat};
endmodule

// File: rtl/agg_chk.sv
module agg_chk #(
  parameter int SRC_W = 32,
  parameter int OUT_N = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_i,
  input logic             addr_i,
  input logic [SRC_W-1:0] wdata_i,
  input logic [SRC_W-1:0] rdata_o,
  input logic [OUT_N-1:0] irq_o,
  input logic             zero_wr_o,
  input logic             ev
);
  // R3
  stat_hi_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_i |-> rdata_o[SRC_W-1:OUT_N] == '0);

  // R6
  zero_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    zero_wr_o |-> $past(wr_i && addr_i && wdata_i == '0));

  // R2
  irq_rise_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(irq_o & ~$past(irq_o))) |-> $past(ev || (wr_i && addr_i)));

  // R5
  irq_fall_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(~irq_o & $past(irq_o))) |-> $past(wr_i && addr_i));

  // R7
  all_ones_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i && (&wdata_i) && !ev) |=> $stable(irq_o));

  // R8
  en_readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !addr_i) |=> (addr_i || rdata_o == $past(wdata_i)));
endmodule

bind intc_fanout_agg agg_chk #(.SRC_W(SRC_W), .OUT_N(OUT_N)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (wr_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .rdata_o  (rdata_o),
  .irq_o    (irq_o),
  .zero_wr_o(zero_wr_o),
  .ev       (ev)
);

// File: tb/tb_intc_fanout_agg.sv
module tb_intc_fanout_agg;
  localparam int CLK_P = 10;
  localparam int W = 32;
  localparam int N = 10;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [W-1:0] src_i = '0;
  logic         wr_i = 1'b0;
  logic         addr_i = 1'b0;
  logic [W-1:0] wdata_i = '0;
  logic [W-1:0] rdata_o;
  logic [N-1:0] irq_o;
  logic         zero_wr_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  logic [W-1:0] m_en = '0, m_sh = '0, m_mask = '0;
  logic [N-1:0] m_stat = '0, m_pend = '0, m_irq = '0;
  logic         m_zero = 1'b0, m_any = 1'b0;

  intc_fanout_agg dut (.*);

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(string req, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "irq", W'(irq_o), W'(m_irq));
    chk(req, "zero_flag", W'(zero_wr_o), W'(m_zero));
    addr_i = 1'b0; #1;
    chk(req, "enable_rd", rdata_o, m_sh);
    addr_i = 1'b1; #1;
    chk(req, "status_rd", rdata_o, W'(m_stat));
  endtask

  task automatic model(bit wr, bit a, logic [W-1:0] d, logic [W-1:0] s);
    logic [W-1:0] ch, sel;
    bit ev;
    ev = (|s) && !m_any;
    m_any = |s;
    m_zero = wr && a && d == '0;
    if (wr && !a) begin
      ch = m_sh ^ d;
      if (d == '0 && m_en == '0) ;
      else if ((m_en | d) != m_en) m_en = m_en | d;
      else if ((ch & d) != '0) m_mask = m_mask & ~ch;
      else m_mask = m_mask | ch;
      m_sh = d;
    end
    if (wr && a && d != '0) begin
      m_stat = m_stat & ~d[N-1:0];
      if (d != '1)
        for (int i = 0; i < N; i++)
          if (d[i]) begin
            if (m_pend[i]) begin m_stat[i] = 1; m_pend[i] = 0; m_irq[i] = 1; end
            else m_irq[i] = 0;
          end
    end
    if (ev) begin
      sel = s & m_en;
      for (int i = 0; i < N; i++)
        if (sel[i]) begin
          if (m_mask[i] || m_stat[i]) m_pend[i] = 1;
          else begin m_stat[i] = 1; m_irq[i] = 1; end
        end
    end
  endtask

  task automatic step(bit wr, bit a, logic [W-1:0] d, logic [W-1:0] s, string req);
    @(negedge clk_i);
    wr_i = wr; addr_i = a; wdata_i = d; src_i = s;
    @(posedge clk_i);
    model(wr, a, d, s);
    #1;
    wr_i = 1'b0;
    check_all(req);
  endtask

  initial begin
    logic [31:0] r;
    logic [W-1:0] d, s;
    repeat (2) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    check_all("R1");

    step(1, 0, 32'h8000_01FF, '0, "R8");
    // single-bit sweep: raise, then acknowledge with nothing pending
    for (int i = 0; i < N; i++) begin
      step(0, 0, '0, W'(1) << i, "R2");
      step(1, 1, W'(1) << i, W'(1) << i, "R5");
      step(0, 0, '0, '0, "R2");
    end
    step(0, 0, '0, 32'h8000_0000, "R3");
    step(0, 0, '0, 32'hFFFF_FC00, "R3");
    step(0, 0, '0, '0, "R3");
    // held source: no second event
    step(0, 0, '0, 32'h1, "R2");
    step(0, 0, '0, 32'h1, "R2");
    // busy bit goes pending, then replays on acknowledge
    step(0, 0, '0, '0, "R4");
    step(0, 0, '0, 32'h1, "R4");
    step(1, 1, 32'h1, 32'h1, "R5");
    step(1, 1, 32'h1, '0, "R5");
    // per-bit independence
    step(0, 0, '0, 32'h5, "R2");
    step(1, 1, 32'h4, 32'h5, "R5");
    step(1, 1, '0, '0, "R6");
    // all-ones write keeps outputs and pending
    step(0, 0, '0, 32'h1, "R4");
    step(1, 1, 32'hFFFF_FFFF, '0, "R7");
    step(1, 1, 32'h1, '0, "R7");
    step(1, 1, 32'h1, '0, "R5");
    // collision: enable bit 9 in the event cycle
    step(1, 0, 32'h0000_0200, 32'h200, "R10");
    step(1, 1, 32'h200, '0, "R5");
    // mask via zero write, event goes pending, unmask, replay
    step(1, 0, '0, '0, "R9");
    step(0, 0, '0, 32'h200, "R9");
    step(1, 0, 32'h200, '0, "R9");
    step(1, 1, 32'h200, '0, "R9");
    step(1, 1, 32'h200, '0, "R5");
    // mixed sweep
    r = 32'h1234_5678;
    for (int k = 0; k < 400; k++) begin
      r = r ^ (r << 13); r = r ^ (r >> 17); r = r ^ (r << 5);
      case (r[3:2])
        2'd0: d = '0;
        2'd1: d = '1;
        default: d = {r[31], 21'b0, r[13:4]};
      endcase
      s = r[21] ? {r[30], 21'b0, r[29:22], r[15:14]} : '0;
      step(r[0], r[1], d, s, "R10");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule